// File: doc/BRIEF.md
# Command Set Controller Register Bank

This block is a memory-mapped register bank for a controller that sends power requests. It holds a small array of command sets. Each set has up to sixteen command slots, and each slot holds a message word, a target address, a data word, a status word and a response word. Software reaches every register over a plain 32-bit read/write bus.

To start a transfer, software first selects slots with the per-set enable mask. It then sets the mode-enable bit of the set's control word, and only after that sets the trigger bit. A sequencer then walks the enabled slots, lowest index first. For each slot it marks the command issued. After a stub latency it marks the command completed and copies the data word into the response word. When the walk ends, the set's interrupt status bit is raised. There is no real downstream traffic: the stub's fixed latency stands in for it.

Read data is combinational from the bus address. Writes take effect at the clock edge on which both the request and write strobes are high.

Top module: `cset_regbank`

## Requirements
- R1: After reset, every writable register reads zero, every set's status word reads 1 (idle), every command status reads zero, and `irq_o` is low.
- R2: Address 0x0C reads the set count in a 6-bit field at bit 6*REQ_ID and the slot count in a 5-bit field at bits 31:27. Address 0x04 reads the solver flag at bit 24. Writes to either address change nothing.
- R3: The common interrupt registers sit at SET_BASE+0x00/0x04/0x08. Set s has its wait mask, control, status and command enable at SET_BASE+672*s plus 0x10/0x14/0x18/0x1C. Slot c has message/address/data/status/response at SET_BASE+672*s+0x30+20*c plus 0x00/0x04/0x08/0x0C/0x10. Any other address reads zero.
- R4: A message word keeps only bits 16 (write), 8 (response request) and 7:0 (length); written values read back ANDed with 0x000101FF.
- R5: A transfer starts only when a control write sets trigger (bit 24) while the stored trigger is 0 and the stored mode enable (bit 16) is already 1. Setting both bits in one write, or rewriting an already-set trigger, starts nothing.
- R6: A control write that clears mode enable leaves it set if the stored trigger is 1. Teardown therefore takes one write that clears trigger, then a second write that clears enable.
- R7: A transfer visits only enabled slots, in ascending order. Each visited slot ends with status bit 8 (issued) and bit 16 (completed) set, and its response word equals its data word. Unvisited slots keep status zero. The set status word reads 0 while the set is busy.
- R8: A command's completed bit appears exactly LAT cycles after its issued bit.
- R9: A set's interrupt status bit rises when its transfer ends. `irq_o` is the OR over sets of status AND enable. The enable register keeps only NSETS bits.
- R10: Writing 1 to a bit of the interrupt clear register clears the matching status bit. The clear register reads zero.
- R11: While a set is busy, writes to its wait mask, command enable and slot message/address/data registers are ignored.
- R12: Starting a transfer clears the issued and completed bits of every slot in that set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write qualifier for the access |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, zero when idle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume the bus presents only word-aligned addresses. They also assume the slot-enable mask of a set is not changed while the set is busy, which the busy lock guarantees. Both the stimulus table and the directed sequences compute every address from the stride rules, so no access falls between words. The sequences drive control writes only in the enable-then-trigger and trigger-off-then-enable-off orders, except where a test deliberately breaks the order to show that no start or no enable drop follows.

// File: rtl/cset_pkg.sv
`timescale 1ns/1ps
package cset_pkg;
  typedef enum logic [3:0] {
    RK_NONE, RK_SOLVER, RK_CFG, RK_IEN, RK_ISTS, RK_ICLR,
    RK_WAIT, RK_CTRL, RK_STAT, RK_CMDEN,
    RK_MSG, RK_ADR, RK_DAT, RK_CST, RK_RSP
  } reg_kind_e;

  localparam int unsigned SET_STRIDE   = 672;
  localparam int unsigned CMD_STRIDE   = 20;
  localparam int unsigned CMD_FIRST    = 32'h30;
  localparam int unsigned CTRL_EN_BIT  = 16;
  localparam int unsigned CTRL_TRG_BIT = 24;
  localparam int unsigned CST_ISS_BIT  = 8;
  localparam int unsigned CST_CMP_BIT  = 16;
  localparam int unsigned SOLVER_BIT   = 24;
  localparam int unsigned CFG_NCMD_LSB = 27;
  localparam int unsigned CFG_NSET_W   = 6;
  localparam logic [31:0] MSG_KEEP     = 32'h0001_01FF;
endpackage

// File: rtl/cset_decode.sv
`timescale 1ns/1ps
module cset_decode
  import cset_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NSETS    = 3,
  parameter int NCMD     = 16,
  parameter int SET_BASE = 32'h200,
  localparam int SET_W   = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int CMD_W   = (NCMD > 1) ? $clog2(NCMD) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [SET_W-1:0]  set_o,
  output logic [CMD_W-1:0]  cmd_o
);
  always_comb begin
    logic [31:0] a, sb, cb;
    kind_o = RK_NONE;
    set_o  = '0;
    cmd_o  = '0;
    a      = 32'(addr_i);
    sb     = '0;
    cb     = '0;
    if (a == 32'h4)                  kind_o = RK_SOLVER;
    if (a == 32'hC)                  kind_o = RK_CFG;
    if (a == 32'(SET_BASE))          kind_o = RK_IEN;
    if (a == 32'(SET_BASE) + 32'h4)  kind_o = RK_ISTS;
    if (a == 32'(SET_BASE) + 32'h8)  kind_o = RK_ICLR;
    for (int s = 0; s < NSETS; s++) begin
      sb = 32'(SET_BASE) + 32'(s) * SET_STRIDE;
      if (a == sb + 32'h10) begin kind_o = RK_WAIT;  set_o = SET_W'(s); end
      if (a == sb + 32'h14) begin kind_o = RK_CTRL;  set_o = SET_W'(s); end
      if (a == sb + 32'h18) begin kind_o = RK_STAT;  set_o = SET_W'(s); end
      if (a == sb + 32'h1C) begin kind_o = RK_CMDEN; set_o = SET_W'(s); end
      for (int c = 0; c < NCMD; c++) begin
        cb = sb + CMD_FIRST + 32'(c) * CMD_STRIDE;
        if (a == cb)          begin kind_o = RK_MSG; set_o = SET_W'(s); cmd_o = CMD_W'(c); end
        if (a == cb + 32'h4)  begin kind_o = RK_ADR; set_o = SET_W'(s); cmd_o = CMD_W'(c); end
        if (a == cb + 32'h8)  begin kind_o = RK_DAT; set_o = SET_W'(s); cmd_o = CMD_W'(c); end
        if (a == cb + 32'hC)  begin kind_o = RK_CST; set_o = SET_W'(s); cmd_o = CMD_W'(c); end
        if (a == cb + 32'h10) begin kind_o = RK_RSP; set_o = SET_W'(s); cmd_o = CMD_W'(c); end
      end
    end
  end
endmodule

// File: rtl/cset_seq.sv
`timescale 1ns/1ps
module cset_seq #(
  parameter int NCMD = 16,
  parameter int LAT  = 3,
  localparam int CMD_W = (NCMD > 1) ? $clog2(NCMD) : 1,
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NCMD-1:0] cmd_en_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [NCMD-1:0] issue_o,
  output logic [NCMD-1:0] compl_o
);
  logic             busy_q, wait_q;
  logic [CMD_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_en, last, fin, step;

  assign cur_en  = cmd_en_i[idx_q];
  assign last    = (idx_q == CMD_W'(NCMD - 1));
  assign fin     = wait_q && (cnt_q == '0);
  assign step    = busy_q && ((!wait_q && !cur_en) || fin);
  assign done_o  = step && last;
  assign busy_o  = busy_q;
  assign issue_o = (busy_q && !wait_q && cur_en) ? (NCMD'(1) << idx_q) : '0;
  assign compl_o = (busy_q && fin) ? (NCMD'(1) << idx_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        wait_q <= 1'b0;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end else if (!wait_q && cur_en) begin
      wait_q <= 1'b1;
      cnt_q  <= CNT_W'(LAT - 1);
    end else if (wait_q && !fin) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      wait_q <= 1'b0;
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  // R7
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/cset_irq.sv
`timescale 1ns/1ps
module cset_irq #(
  parameter int NSETS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSETS-1:0] done_i,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic [NSETS-1:0] wdata_i,
  output logic [NSETS-1:0] en_o,
  output logic [NSETS-1:0] sts_o,
  output logic             irq_o
);
  logic [NSETS-1:0] en_q, sts_q, clr;

  assign clr   = clr_we_i ? wdata_i : '0;
  assign en_o  = en_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      sts_q <= (sts_q & ~clr) | done_i; // a finishing set wins over a clear
    end
  end

  // R9
  sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |done_i |=> ((sts_q & $past(done_i)) == $past(done_i)));
  // R10
  sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((sts_q & $past(wdata_i & ~done_i)) == '0));
endmodule

// File: rtl/cset_set.sv
`timescale 1ns/1ps
module cset_set
  import cset_pkg::*;
#(
  parameter int NCMD = 16,
  parameter int LAT  = 3,
  localparam int CMD_W = (NCMD > 1) ? $clog2(NCMD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  reg_kind_e        kind_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             done_o
);
  logic [NCMD-1:0] wait_q, cmden_q, iss_q, cmp_q, issue, compl;
  logic            en_q, trig_q, busy, wr, start, lock;
  logic [31:0]     msg_q [NCMD];
  logic [31:0]     adr_q [NCMD];
  logic [31:0]     dat_q [NCMD];
  logic [31:0]     rsp_q [NCMD];
  logic [31:0]     rd;

  assign wr    = sel_i && we_i;
  assign lock  = busy;
  assign start = wr && (kind_i == RK_CTRL) && wdata_i[CTRL_TRG_BIT] &&
                 !trig_q && en_q && !busy;

  cset_seq #(.NCMD(NCMD), .LAT(LAT)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cmd_en_i (cmden_q),
    .busy_o   (busy),
    .done_o   (done_o),
    .issue_o  (issue),
    .compl_o  (compl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      trig_q  <= 1'b0;
      wait_q  <= '0;
      cmden_q <= '0;
      iss_q   <= '0;
      cmp_q   <= '0;
    end else begin
      if (wr && kind_i == RK_CTRL) begin
        trig_q <= wdata_i[CTRL_TRG_BIT];
        en_q   <= wdata_i[CTRL_EN_BIT] | trig_q; // enable drops only after trigger
      end
      if (wr && !lock && kind_i == RK_WAIT)  wait_q  <= wdata_i[NCMD-1:0];
      if (wr && !lock && kind_i == RK_CMDEN) cmden_q <= wdata_i[NCMD-1:0];
      if (start) begin
        iss_q <= '0;
        cmp_q <= '0;
      end else begin
        iss_q <= iss_q | issue;
        cmp_q <= cmp_q | compl;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCMD; c++) begin
        msg_q[c] <= '0;
        adr_q[c] <= '0;
        dat_q[c] <= '0;
        rsp_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCMD; c++) begin
        if (wr && !lock && cmd_i == CMD_W'(c)) begin
          if (kind_i == RK_MSG) msg_q[c] <= wdata_i & MSG_KEEP;
          if (kind_i == RK_ADR) adr_q[c] <= wdata_i;
          if (kind_i == RK_DAT) dat_q[c] <= wdata_i;
        end
        if (compl[c]) rsp_q[c] <= dat_q[c];
      end
    end
  end

  always_comb begin
    rd = '0;
    unique case (kind_i)
      RK_WAIT:  rd = 32'(wait_q);
      RK_CTRL: begin
        rd[CTRL_TRG_BIT] = trig_q;
        rd[CTRL_EN_BIT]  = en_q;
      end
      RK_STAT:  rd = {31'b0, !busy};
      RK_CMDEN: rd = 32'(cmden_q);
      RK_MSG:   rd = msg_q[cmd_i];
      RK_ADR:   rd = adr_q[cmd_i];
      RK_DAT:   rd = dat_q[cmd_i];
      RK_CST: begin
        rd[CST_ISS_BIT] = iss_q[cmd_i];
        rd[CST_CMP_BIT] = cmp_q[cmd_i];
      end
      RK_RSP:   rd = rsp_q[cmd_i];
      default:  rd = '0;
    endcase
  end

  assign rdata_o = sel_i ? rd : '0;

  // R7
  cst_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q & ~iss_q) == '0);
  // R11
  busy_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && wr && (kind_i == RK_CMDEN) |=> $stable(cmden_q));
  // R6
  teardown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> en_q);
  // R12
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (iss_q == '0) && (cmp_q == '0));
endmodule

// File: rtl/cset_regbank.sv
`timescale 1ns/1ps
module cset_regbank
  import cset_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NSETS     = 3,
  parameter int NCMD      = 16,
  parameter int LAT       = 3,
  parameter int SET_BASE  = 32'h200,
  parameter int REQ_ID    = 0,
  parameter bit HW_SOLVER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1;
  localparam int CMD_W = (NCMD > 1) ? $clog2(NCMD) : 1;
  localparam logic [31:0] CFG_WORD =
    (32'(NSETS) << (CFG_NSET_W * REQ_ID)) | (32'(NCMD) << CFG_NCMD_LSB);
  localparam logic [31:0] SOLVER_WORD = 32'(HW_SOLVER) << SOLVER_BIT;

  reg_kind_e        kind;
  logic [SET_W-1:0] set_idx;
  logic [CMD_W-1:0] cmd_idx;
  logic             wr, set_kind;
  logic [NSETS-1:0] done_w, ien, ists;
  logic [31:0]      set_rd [NSETS];
  logic [31:0]      set_or, rd;

  assign wr       = bus_req_i && bus_we_i;
  assign set_kind = (kind >= RK_WAIT);

  cset_decode #(
    .ADDR_W(ADDR_W), .NSETS(NSETS), .NCMD(NCMD), .SET_BASE(SET_BASE)
  ) u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .set_o  (set_idx),
    .cmd_o  (cmd_idx)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    cset_set #(.NCMD(NCMD), .LAT(LAT)) u_set (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (set_kind && (set_idx == SET_W'(s))),
      .we_i    (wr),
      .kind_i  (kind),
      .cmd_i   (cmd_idx),
      .wdata_i (bus_wdata_i),
      .rdata_o (set_rd[s]),
      .done_o  (done_w[s])
    );
  end

  cset_irq #(.NSETS(NSETS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_w),
    .en_we_i  (wr && kind == RK_IEN),
    .clr_we_i (wr && kind == RK_ICLR),
    .wdata_i  (bus_wdata_i[NSETS-1:0]),
    .en_o     (ien),
    .sts_o    (ists),
    .irq_o    (irq_o)
  );

  always_comb begin
    set_or = '0;
    for (int s = 0; s < NSETS; s++) set_or = set_or | set_rd[s];
  end

  always_comb begin
    case (kind)
      RK_SOLVER: rd = SOLVER_WORD;
      RK_CFG:    rd = CFG_WORD;
      RK_IEN:    rd = 32'(ien);
      RK_ISTS:   rd = 32'(ists);
      default:   rd = set_or; // clear register and unmapped read zero
    endcase
  end

  assign bus_rdata_o = bus_req_i ? rd : '0;

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ists & ien) != '0));
endmodule

// File: tb/cset_regbank_tb.sv
`timescale 1ns/1ps
module cset_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  cset_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h00C, 32'h8000_0003, 4'd2},  // R2 config word
    '{1'b1, 12'h00C, 32'hFFFF_FFFF, 4'd2},
    '{1'b0, 12'h00C, 32'h8000_0003, 4'd2},  // R2 read-only
    '{1'b0, 12'h004, 32'h0100_0000, 4'd2},  // R2 solver flag
    '{1'b1, 12'h230, 32'hFFFF_FFFF, 4'd4},
    '{1'b0, 12'h230, 32'h0001_01FF, 4'd4},  // R4 mask
    '{1'b1, 12'h244, 32'h0001_0008, 4'd4},
    '{1'b0, 12'h244, 32'h0001_0008, 4'd4},  // R4
    '{1'b1, 12'h4E8, 32'hDEAD_BEEF, 4'd3},
    '{1'b0, 12'h4E8, 32'hDEAD_BEEF, 4'd3},  // R3 set1 slot1 address
    '{1'b1, 12'h778, 32'h1234_5678, 4'd3},
    '{1'b0, 12'h778, 32'h1234_5678, 4'd3},  // R3 set2 slot0 data
    '{1'b1, 12'h4B0, 32'h0000_A5A5, 4'd3},
    '{1'b0, 12'h4B0, 32'h0000_A5A5, 4'd3},  // R3 set1 wait mask
    '{1'b0, 12'h20C, 32'h0000_0000, 4'd3},  // R3 unmapped
    '{1'b0, 12'h4A0, 32'h0000_0000, 4'd3},  // R3 unmapped
    '{1'b0, 12'hFFC, 32'h0000_0000, 4'd3},  // R3 unmapped
    '{1'b1, 12'h208, 32'h0000_0007, 4'd10},
    '{1'b0, 12'h208, 32'h0000_0000, 4'd10}, // R10 clear reads zero
    '{1'b0, 12'h758, 32'h0000_0001, 4'd1},  // R1 idle status
    '{1'b0, 12'h77C, 32'h0000_0000, 4'd1},  // R1 command status
    '{1'b1, 12'h200, 32'hFFFF_FFFF, 4'd9},
    '{1'b0, 12'h200, 32'h0000_0007, 4'd9},  // R9 enable width
    '{1'b1, 12'h200, 32'h0000_0000, 4'd9}
  };

  function automatic logic [11:0] reg_a(input int s, input int off);
    return 12'(32'h200 + 672 * s + off);
  endfunction

  function automatic logic [11:0] cmd_a(input int s, input int c, input int off);
    return 12'(32'h200 + 672 * s + 48 + 20 * c + off);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle(input int s);
    logic [31:0] v;
    for (int i = 0; i < 1000; i++) begin
      bus_rd(reg_a(s, 'h18), v);
      if (v[0]) return;
    end
    check("R7 idle timeout", v, 32'h1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int t_iss, t_cmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq", 32'(irq), 32'h0);
    bus_rd(reg_a(0, 'h14), v); check("R1 ctrl", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) bus_wr(VEC[i].a, VEC[i].d);
      else begin
        bus_rd(VEC[i].a, v);
        check($sformatf("R%0d vector %0d", VEC[i].rq, i), v, VEC[i].d);
      end
    end

    // set 0: slots 0,1,3 enabled
    for (int c = 0; c < 4; c++) bus_wr(cmd_a(0, c, 8), 32'h100 + c);
    bus_wr(reg_a(0, 'h1C), 32'hB);
    bus_wr(reg_a(0, 'h14), 32'h0101_0000);         // both at once
    repeat (10) @(negedge clk);
    bus_rd(reg_a(0, 'h18), v); check("R5 no start idle", v, 32'h1);
    bus_rd(cmd_a(0, 0, 'hC), v); check("R5 no start status", v, 32'h0);
    bus_wr(reg_a(0, 'h14), 32'h0);
    bus_rd(reg_a(0, 'h14), v); check("R6 enable held", v, 32'h0001_0000);
    bus_wr(reg_a(0, 'h14), 32'h0);
    bus_rd(reg_a(0, 'h14), v); check("R6 enable dropped", v, 32'h0);
    bus_wr(reg_a(0, 'h14), 32'h0001_0000);
    bus_wr(reg_a(0, 'h14), 32'h0101_0000);
    bus_rd(reg_a(0, 'h18), v); check("R7 busy status", v, 32'h0);
    bus_wr(reg_a(0, 'h1C), 32'hFFFF);
    bus_rd(reg_a(0, 'h1C), v); check("R11 cmd enable locked", v, 32'hB);
    bus_wr(cmd_a(0, 0, 8), 32'h999);
    bus_rd(cmd_a(0, 0, 8), v); check("R11 data locked", v, 32'h100);
    wait_idle(0);
    bus_rd(cmd_a(0, 0, 'hC), v); check("R7 slot0 status", v, 32'h0001_0100);
    bus_rd(cmd_a(0, 1, 'hC), v); check("R7 slot1 status", v, 32'h0001_0100);
    bus_rd(cmd_a(0, 2, 'hC), v); check("R7 slot2 skipped", v, 32'h0);
    bus_rd(cmd_a(0, 3, 'hC), v); check("R7 slot3 status", v, 32'h0001_0100);
    bus_rd(cmd_a(0, 3, 'h10), v); check("R7 slot3 response", v, 32'h103);
    bus_rd(cmd_a(0, 2, 'h10), v); check("R7 slot2 response", v, 32'h0);
    bus_rd(reg_a(0, 4), v); check("R9 status raised", v, 32'h1);
    #1 check("R9 irq masked", 32'(irq), 32'h0);
    bus_wr(reg_a(0, 0), 32'h1);
    #1 check("R9 irq enabled", 32'(irq), 32'h1);
    bus_wr(reg_a(0, 8), 32'h1);
    bus_rd(reg_a(0, 4), v); check("R10 status cleared", v, 32'h0);
    #1 check("R10 irq low", 32'(irq), 32'h0);

    // rewrite of a held trigger must not restart
    bus_wr(reg_a(0, 'h14), 32'h0101_0000);
    repeat (5) @(negedge clk);
    bus_rd(reg_a(0, 4), v); check("R5 held trigger", v, 32'h0);
    bus_wr(reg_a(0, 'h1C), 32'h4);
    bus_wr(reg_a(0, 'h14), 32'h0001_0000);
    bus_wr(reg_a(0, 'h14), 32'h0101_0000);
    wait_idle(0);
    bus_rd(cmd_a(0, 0, 'hC), v); check("R12 old status cleared", v, 32'h0);
    bus_rd(cmd_a(0, 2, 'hC), v); check("R7 slot2 status", v, 32'h0001_0100);
    #1 check("R9 irq retrigger", 32'(irq), 32'h1);
    bus_wr(reg_a(0, 8), 32'h1);

    // set 1 with no enabled slot
    bus_wr(reg_a(1, 'h1C), 32'h0);
    bus_wr(reg_a(1, 'h14), 32'h0001_0000);
    bus_wr(reg_a(1, 'h14), 32'h0101_0000);
    wait_idle(1);
    bus_rd(reg_a(0, 4), v); check("R9 empty set status", v, 32'h2);
    #1 check("R9 other set masked", 32'(irq), 32'h0);
    bus_wr(reg_a(0, 8), 32'h2);

    // set 2: issue-to-complete latency on slot 0
    bus_wr(reg_a(2, 'h1C), 32'h1);
    bus_wr(reg_a(2, 'h14), 32'h0001_0000);
    bus_wr(reg_a(2, 'h14), 32'h0101_0000);
    t_iss = -1; t_cmp = -1;
    for (int i = 0; i < 40; i++) begin
      bus_rd(cmd_a(2, 0, 'hC), v);
      if (v[8] && t_iss < 0) t_iss = i;
      if (v[16] && t_cmp < 0) t_cmp = i;
    end
    check("R8 latency", 32'(t_cmp - t_iss), 32'd3);
    bus_rd(cmd_a(2, 0, 'h10), v); check("R7 set2 response", v, 32'h1234_5678);

    finish_run();
  end
endmodule